// File: doc/BRIEF.md
# Pointer-Indexed Calendar Register Window

This block puts a calendar timer register set and an alarm register set behind a narrow bus. Each set is reached through a single 16-bit window with a high byte lane and a low byte lane. A 2-bit pointer picks which pair of byte-wide fields the window shows. The block stores the fields and presents them in flat form to the time-counting and alarm-matching logic next to it. Each set also has a configuration word whose bits 9:8 hold that set's pointer.

The pointer moves down by one on most window accesses and stops at 00, so software can load the pointer once and then sweep every field with repeated accesses. Any window read moves it. A window write moves it only when the high byte lane is written. Writes through the timer window change storage only while the external write-enable input is high. Alarm writes are never gated.

The bus has no back-pressure. Each cycle with `acc_valid` high is one complete access. A read returns its data one cycle later, with `rd_valid` high for exactly one cycle.

Top module: `calwin_regs`

## Requirements
- R1: After reset both pointers are 00, every stored field is zero and `rd_valid` is low.
- R2: Targets are encoded as `acc_target` 0 = timer window, 1 = alarm window, 2 = timer configuration, 3 = alarm configuration. The timer pointer picks the field pairs as follows, with the high lane given first: 00 minutes/seconds, 01 weekday/hours, 10 month/day, 11 unused/year. `time_flat` is {year, month, day, weekday, hours, minutes, seconds}, with seconds in bits 7:0.
- R3: A window read (`acc_write` low), with any byte enables, sets `rd_valid` high one cycle later. `rd_data` carries the pair selected by the pointer value from before the access, and the pointer then decreases by one.
- R4: A pointer at 00 stays at 00 on every window access.
- R5: A window write with `acc_be[1]` set (high lane) decreases the pointer. A write with `acc_be` = 01 (low lane only) updates only the low field and leaves the pointer unchanged.
- R6: A timer window write while `wr_unlock` is low leaves every timer field unchanged. The pointer still steps as set out in R5.
- R7: The alarm pointer picks the pairs as follows, high lane first: 00 alarm minutes/alarm seconds, 01 alarm weekday/alarm hours, 10 alarm month/alarm day. Alarm writes take effect whatever the level of `wr_unlock`. `alarm_flat` is {month, day, weekday, hours, minutes, seconds}.
- R8: Unused or reserved byte lanes (timer 11 high lane, both alarm 11 lanes) read as zero, and writes to them are ignored.
- R9: A configuration write with `acc_be[1]` set loads the pointer from `acc_wdata[9:8]`. A configuration read returns the pointer in bits 9:8 with all other bits zero, and it does not move the pointer.
- R10: Accesses to the timer targets never change the alarm pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_unlock | input | 1 | Enables writes to timer storage (driven by the lock logic) |
| acc_valid | input | 1 | Access strobe, one access per cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_target | input | 2 | Selected window or configuration word |
| acc_be | input | 2 | Byte enables, bit 1 = high lane |
| acc_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 16 | Read data |
| time_flat | output | 56 | Stored timer fields |
| alarm_flat | output | 48 | Stored alarm fields |

## Verification
The timer window is swept downward from pointer 11 with full-word writes, which separates correct field placement from lane swaps and off-by-one slot errors. It is then read back with low-lane-only enables, which shows that reads decrement whatever the enables are. A write with only the low lane enabled, done at a nonzero pointer, separates the two decrement rules. Repeated accesses at 00 expose any wrap to 11. A locked write shows that the timer gate blocks only storage and still lets the pointer move. Alarm writes with the lock closed, together with timer configuration reads that follow alarm activity, show that the two sets are independent.

// File: rtl/calwin_pkg.sv
package calwin_pkg;
  typedef enum logic [1:0] {
    TGT_TWIN = 2'd0,
    TGT_AWIN = 2'd1,
    TGT_TCFG = 2'd2,
    TGT_ACFG = 2'd3
  } tgt_e;
endpackage

// File: rtl/calwin_ptr.sv
// Saturating down-counting window pointer with direct load.
module calwin_ptr #(
  parameter int PTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  input  logic             step,
  output logic [PTR_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      ptr <= '0;
    else if (load)
      ptr <= load_val;
    else if (step && (ptr != '0))
      ptr <= ptr - 1'b1;
  end
endmodule

// File: rtl/calwin_bank.sv
// Field storage addressed by {pointer, lane}; unused slots are constant zero.
module calwin_bank #(
  parameter int          FIELD_W   = 8,
  parameter int          PTR_W     = 2,
  parameter logic [7:0]  USED_MASK = 8'h7F
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [PTR_W-1:0]            ptr,
  input  logic                        wr_en,
  input  logic [1:0]                  wr_be,
  input  logic [2*FIELD_W-1:0]        wr_data,
  output logic [2*FIELD_W-1:0]        rd_word,
  output logic [(2**(PTR_W+1))*FIELD_W-1:0] slots_flat
);
  localparam int SLOTS = 2**(PTR_W+1);

  logic [FIELD_W-1:0] slot_q [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam int LANE = s % 2;
    if (USED_MASK[s]) begin : g_used
      always_ff @(posedge clk) begin
        if (!rst_n)
          slot_q[s] <= '0;
        else if (wr_en && wr_be[LANE] && (ptr == PTR_W'(s / 2)))
          slot_q[s] <= wr_data[LANE*FIELD_W +: FIELD_W];
      end
    end else begin : g_unused
      assign slot_q[s] = '0;
    end
    assign slots_flat[s*FIELD_W +: FIELD_W] = slot_q[s];
  end

  assign rd_word = {slot_q[{ptr, 1'b1}], slot_q[{ptr, 1'b0}]};
endmodule

// File: rtl/calwin_regs.sv
module calwin_regs
  import calwin_pkg::*;
#(
  parameter int FIELD_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_unlock,
  input  logic                 acc_valid,
  input  logic                 acc_write,
  input  logic [1:0]           acc_target,
  input  logic [1:0]           acc_be,
  input  logic [2*FIELD_W-1:0] acc_wdata,
  output logic                 rd_valid,
  output logic [2*FIELD_W-1:0] rd_data,
  output logic [7*FIELD_W-1:0] time_flat,
  output logic [6*FIELD_W-1:0] alarm_flat
);
  localparam int PTR_W   = 2;
  localparam int PTR_LSB = FIELD_W;
  localparam int WORD_W  = 2*FIELD_W;
  localparam int SLOTS   = 2**(PTR_W+1);

  logic is_twin, is_awin, is_tcfg, is_acfg;
  logic t_step, a_step, t_load, a_load;
  logic [PTR_W-1:0] t_ptr, a_ptr;
  logic [WORD_W-1:0] t_word, a_word, rd_mux;
  logic [SLOTS*FIELD_W-1:0] t_slots, a_slots;

  assign is_twin = acc_valid && (acc_target == TGT_TWIN);
  assign is_awin = acc_valid && (acc_target == TGT_AWIN);
  assign is_tcfg = acc_valid && (acc_target == TGT_TCFG);
  assign is_acfg = acc_valid && (acc_target == TGT_ACFG);

  // Reads always step; writes step only when the high lane is written.
  assign t_step = is_twin && (!acc_write || acc_be[1]);
  assign a_step = is_awin && (!acc_write || acc_be[1]);
  assign t_load = is_tcfg && acc_write && acc_be[1];
  assign a_load = is_acfg && acc_write && acc_be[1];

  calwin_ptr #(.PTR_W(PTR_W)) t_ptr_i (
    .clk(clk), .rst_n(rst_n), .load(t_load),
    .load_val(acc_wdata[PTR_LSB +: PTR_W]), .step(t_step), .ptr(t_ptr));

  calwin_ptr #(.PTR_W(PTR_W)) a_ptr_i (
    .clk(clk), .rst_n(rst_n), .load(a_load),
    .load_val(acc_wdata[PTR_LSB +: PTR_W]), .step(a_step), .ptr(a_ptr));

  calwin_bank #(.FIELD_W(FIELD_W), .PTR_W(PTR_W), .USED_MASK(8'h7F)) t_bank_i (
    .clk(clk), .rst_n(rst_n), .ptr(t_ptr),
    .wr_en(is_twin && acc_write && wr_unlock),
    .wr_be(acc_be), .wr_data(acc_wdata),
    .rd_word(t_word), .slots_flat(t_slots));

  calwin_bank #(.FIELD_W(FIELD_W), .PTR_W(PTR_W), .USED_MASK(8'h3F)) a_bank_i (
    .clk(clk), .rst_n(rst_n), .ptr(a_ptr),
    .wr_en(is_awin && acc_write),
    .wr_be(acc_be), .wr_data(acc_wdata),
    .rd_word(a_word), .slots_flat(a_slots));

  always_comb begin
    rd_mux = '0;
    case (tgt_e'(acc_target))
      TGT_TWIN: rd_mux = t_word;
      TGT_AWIN: rd_mux = a_word;
      TGT_TCFG: rd_mux[PTR_LSB +: PTR_W] = t_ptr;
      TGT_ACFG: rd_mux[PTR_LSB +: PTR_W] = a_ptr;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= acc_valid && !acc_write;
      if (acc_valid && !acc_write)
        rd_data <= rd_mux;
    end
  end

  assign time_flat  = t_slots[7*FIELD_W-1:0];
  assign alarm_flat = a_slots[6*FIELD_W-1:0];
endmodule

// File: rtl/calwin_regs_chk.sv
module calwin_regs_chk #(
  parameter int FIELD_W = 8,
  parameter int PTR_W   = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_unlock,
  input logic                 acc_valid,
  input logic                 acc_write,
  input logic [1:0]           acc_target,
  input logic [1:0]           acc_be,
  input logic [PTR_W-1:0]     t_ptr,
  input logic [PTR_W-1:0]     a_ptr,
  input logic                 rd_valid,
  input logic [7*FIELD_W-1:0] time_flat
);
  p_read_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && acc_target == 2'd0 && t_ptr != '0)
      |=> (t_ptr == PTR_W'($past(t_ptr) - 1'b1)));

  p_rd_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |=> rd_valid);

  p_no_rd_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && !acc_write) |=> !rd_valid);

  p_sat_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_target == 2'd0 && t_ptr == '0) |=> (t_ptr == '0));

  p_low_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_target == 2'd0 && acc_be == 2'b01)
      |=> $stable(t_ptr));

  p_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_target == 2'd0 && !wr_unlock)
      |=> $stable(time_flat));

  p_cfg_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && acc_target == 2'd2) |=> $stable(t_ptr));

  p_indep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (acc_target == 2'd0 || acc_target == 2'd2)) |=> $stable(a_ptr));
endmodule

bind calwin_regs calwin_regs_chk #(.FIELD_W(FIELD_W), .PTR_W(PTR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_unlock(wr_unlock), .acc_valid(acc_valid),
  .acc_write(acc_write), .acc_target(acc_target), .acc_be(acc_be),
  .t_ptr(t_ptr), .a_ptr(a_ptr), .rd_valid(rd_valid), .time_flat(time_flat));

// File: tb/calwin_regs_tb.sv
module calwin_regs_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_unlock = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [1:0]  acc_target = '0;
  logic [1:0]  acc_be = '0;
  logic [15:0] acc_wdata = '0;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic [55:0] time_flat;
  logic [47:0] alarm_flat;

  int n_checks = 0;
  int n_fail   = 0;
  logic [15:0] exp_q[$];
  string       req_q[$];

  always #(CLK_P/2) clk = ~clk;

  calwin_regs dut_i (
    .clk(clk), .rst_n(rst_n), .wr_unlock(wr_unlock), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_target(acc_target), .acc_be(acc_be),
    .acc_wdata(acc_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .time_flat(time_flat), .alarm_flat(alarm_flat));

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [1:0] tgt, input logic [1:0] be,
                        input logic [15:0] data);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_target = tgt; acc_be = be; acc_wdata = data;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic wr(input logic [1:0] tgt, input logic [1:0] be, input logic [15:0] d);
    access(1'b1, tgt, be, d);
  endtask

  // Driver: push the expected word, then issue the read.
  task automatic rd(input logic [1:0] tgt, input logic [1:0] be,
                    input logic [15:0] exp, input string req);
    exp_q.push_back(exp);
    req_q.push_back(req);
    access(1'b0, tgt, be, 16'h0000);
  endtask

  // Monitor: compare each returned word with the scoreboard head.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected rd_valid", {48'h0, rd_data}, 64'h0);
      end else begin
        logic [15:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(rd_data === e, r, {48'h0, rd_data}, {48'h0, e});
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    check(1'b0, "watchdog", 64'h0, 64'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rd_valid === 1'b0, "R1 rd_valid", {63'h0, rd_valid}, 64'h0);
    check(time_flat === '0, "R1 time_flat", {8'h0, time_flat}, 64'h0);
    check(alarm_flat === '0, "R1 alarm_flat", {16'h0, alarm_flat}, 64'h0);
    rd(2'd2, 2'b11, 16'h0000, "R1 timer pointer");

    // R9 pointer load and non-moving configuration reads
    wr_unlock = 1'b1;
    wr(2'd2, 2'b10, 16'h0300);
    rd(2'd2, 2'b11, 16'h0300, "R9 cfg read");
    rd(2'd2, 2'b11, 16'h0300, "R9 cfg read again");

    // R2 sweep with full writes; R8 unused high lane; R4 saturation on write
    wr(2'd0, 2'b11, 16'hAB24);
    wr(2'd0, 2'b11, 16'h1231);
    wr(2'd0, 2'b11, 16'h0523);
    wr(2'd0, 2'b11, 16'h5958);
    wr(2'd0, 2'b11, 16'h5958);
    check(time_flat === 56'h24_1231_0523_5958, "R2 time_flat layout",
          {8'h0, time_flat}, {8'h0, 56'h24_1231_0523_5958});
    rd(2'd2, 2'b11, 16'h0000, "R4 pointer held at 00");

    // R5 low-lane write keeps pointer
    wr(2'd2, 2'b10, 16'h0200);
    wr(2'd0, 2'b01, 16'h0015);
    rd(2'd2, 2'b11, 16'h0200, "R5 low-lane write keeps pointer");

    // R3 reads with any enables, decrement; R4 saturation on read
    rd(2'd0, 2'b11, 16'h1215, "R3 read month/day");
    rd(2'd0, 2'b01, 16'h0523, "R3 low-lane read weekday/hours");
    rd(2'd0, 2'b10, 16'h5958, "R3 read minutes/seconds");
    rd(2'd0, 2'b11, 16'h5958, "R4 read at 00 stays");

    // R8 unused lane reads zero
    wr(2'd2, 2'b10, 16'h0300);
    rd(2'd0, 2'b11, 16'h0024, "R8 timer unused lane");
    rd(2'd2, 2'b11, 16'h0200, "R3 pointer after read at 11");

    // R6 locked write: storage unchanged, pointer still steps
    wr_unlock = 1'b0;
    wr(2'd2, 2'b10, 16'h0100);
    wr(2'd0, 2'b11, 16'h1111);
    check(time_flat === 56'h24_1215_0523_5958, "R6 locked write ignored",
          {8'h0, time_flat}, {8'h0, 56'h24_1215_0523_5958});
    rd(2'd2, 2'b11, 16'h0000, "R6 pointer stepped while locked");

    // R7 alarm writes with lock closed; R8 reserved lanes
    wr(2'd3, 2'b10, 16'h0300);
    wr(2'd1, 2'b11, 16'h7777);
    wr(2'd1, 2'b11, 16'h0615);
    wr(2'd1, 2'b11, 16'h0307);
    wr(2'd1, 2'b11, 16'h3045);
    check(alarm_flat === 48'h0615_0307_3045, "R7 alarm_flat layout",
          {16'h0, alarm_flat}, {16'h0, 48'h0615_0307_3045});
    rd(2'd2, 2'b11, 16'h0000, "R10 timer pointer untouched by alarm");
    rd(2'd3, 2'b11, 16'h0000, "R7 alarm pointer at 00");

    // R10 timer activity leaves alarm pointer
    wr(2'd3, 2'b10, 16'h0200);
    wr(2'd2, 2'b10, 16'h0300);
    rd(2'd0, 2'b11, 16'h0024, "R10 timer read");
    rd(2'd3, 2'b11, 16'h0200, "R10 alarm pointer kept");
    rd(2'd1, 2'b11, 16'h0615, "R7 read alarm month/day");
    rd(2'd1, 2'b01, 16'h0307, "R7 read alarm weekday/hours");
    wr(2'd3, 2'b10, 16'h0300);
    rd(2'd1, 2'b11, 16'h0000, "R8 alarm reserved pair");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R3 all reads returned", exp_q.size(), 64'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule